// File: doc/BRIEF.md
# Two-Tone Fitness Scorer

This block grades a candidate circuit by how cleanly its one-bit digital output tells two test tones apart. A start pulse launches a fixed run of timed measurement windows. Before each window the block selects the stimulus tone through `tone_sel_o`. During the window it counts the sample-enable strobes at which the circuit output is high. The total for each window is added to a running total for the tone that was applied.

The tones alternate, low tone first. Each tone is applied for `REPS` windows, and each window is `WIN_LEN` sample enables long. The defaults are 5 windows of 200,000 enables at 1 MHz, so one evaluation lasts 2 s. At the end the block forms the absolute difference of the two totals. It divides that difference by the number of windows per tone and rescales it to a `FIT_W`-bit score, so that full scale equals one full window of ones. It then presents the score with a one-cycle done pulse.

Top module: `fd_fitness`

## Requirements
- R1: After reset, `fit_o` is 0, `done_o` is 0 and `tone_sel_o` is 0.
- R2: `tone_sel_o` is 0 (low tone) during windows 0, 2, 4, … and 1 (high tone) during odd windows. It changes only at the clock edge that takes the last sample of a window.
- R3: A window ends after exactly `WIN_LEN` cycles with `samp_en_i` high. Cycles with `samp_en_i` low take no sample and do not advance the window.
- R4: Write SL for the number of samples with `dut_bit_i`=1 taken under tone 0, and SH for the number taken under tone 1. Then `fit_o` = floor(|SL−SH|·(2^FIT_W−1) / (REPS·WIN_LEN)).
- R5: `done_o` is high for exactly one cycle, starting at the clock edge after the edge that takes the final sample of window 2·REPS−1. `fit_o` takes its new value at that same edge and holds it until the next done pulse.
- R6: A `start_i` pulse that arrives while an evaluation is running has no effect on the schedule or on the score.
- R7: An accepted start clears both totals, so each evaluation's score depends only on its own samples.
- R8: While idle, `samp_en_i` and `dut_bit_i` have no effect: no done pulse occurs, `tone_sel_o` stays 0 and `fit_o` holds.
- R9: Each total holds up to REPS·WIN_LEN counts without overflow. All ones under one tone and all zeros under the other give a score of 2^FIT_W−1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin an evaluation (accepted when idle) |
| samp_en_i | input | 1 | Sample strobe for the circuit output |
| dut_bit_i | input | 1 | Digital output of the circuit under test |
| tone_sel_o | output | 1 | Tone to apply: 0 low tone, 1 high tone |
| fit_o | output | FIT_W | Fitness score |
| done_o | output | 1 | One-cycle pulse when `fit_o` is new |

## Verification
An input driven after one edge is taken at the next edge, which is called the sampling edge. A sample counts at its sampling edge, and a tone change from a window's last sample appears right after that edge. The bench therefore reads `tone_sel_o` just after the edge that precedes the first sample of each window. The score and `done_o` are registered once more. They are due one edge after the sampling edge of the final sample, so the bench reads them one clock after that final sample and checks on the following clock that `done_o` has dropped. Gaps in the strobe stretch each window by the number of idle cycles and shift no other timing.

// File: rtl/fd_pkg.sv
package fd_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_FIN  = 2'd2
  } fd_state_e;
endpackage

// File: rtl/fd_sequencer.sv
module fd_sequencer
  import fd_pkg::*;
#(
  parameter int unsigned WIN_LEN = 200000,
  parameter int unsigned REPS    = 5
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic samp_en_i,
  output logic clr_o,
  output logic take_o,
  output logic tone_o,
  output logic fin_o
);
  localparam int unsigned NWIN = 2 * REPS;
  localparam int unsigned SW   = $clog2(WIN_LEN);
  localparam int unsigned WW   = $clog2(NWIN);

  fd_state_e   state_q;
  logic [SW-1:0] samp_cnt_q;
  logic [WW-1:0] win_cnt_q;
  logic          tone_q;
  logic          win_end;

  assign clr_o   = (state_q == ST_IDLE) && start_i;
  assign take_o  = (state_q == ST_RUN) && samp_en_i;
  assign win_end = take_o && (samp_cnt_q == SW'(WIN_LEN - 1));
  assign tone_o  = tone_q;
  assign fin_o   = (state_q == ST_FIN);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      samp_cnt_q <= '0;
      win_cnt_q  <= '0;
      tone_q     <= 1'b0;
    end else begin
      case (state_q)
        ST_IDLE: if (start_i) begin
          state_q    <= ST_RUN;
          samp_cnt_q <= '0;
          win_cnt_q  <= '0;
          tone_q     <= 1'b0;
        end
        ST_RUN: if (take_o) begin
          if (win_end) begin
            samp_cnt_q <= '0;
            tone_q     <= ~tone_q;
            if (win_cnt_q == WW'(NWIN - 1)) state_q <= ST_FIN;
            else win_cnt_q <= win_cnt_q + 1'b1;
          end else begin
            samp_cnt_q <= samp_cnt_q + 1'b1;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // R2
  tone_edge_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tone_q != $past(tone_q)) |-> $past(win_end));
  // R3
  samp_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    samp_cnt_q < SW'(WIN_LEN));
  // R5
  fin_once_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fin_o |=> !fin_o);
endmodule

// File: rtl/fd_accum.sv
module fd_accum #(
  parameter int unsigned AW    = 20,
  parameter int unsigned LIMIT = 1000000
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          take_i,
  input  logic          tone_i,
  input  logic          bit_i,
  output logic [AW-1:0] tot_lo_o,
  output logic [AW-1:0] tot_hi_o
);
  logic [AW-1:0] tot_q [2];

  for (genvar t = 0; t < 2; t++) begin : g_tot
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                    tot_q[t] <= '0;
      else if (clr_i)                                 tot_q[t] <= '0;
      else if (take_i && bit_i && (tone_i == 1'(t)))  tot_q[t] <= tot_q[t] + 1'b1;
    end

    // R9
    no_overflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      tot_q[t] <= AW'(LIMIT));
  end

  assign tot_lo_o = tot_q[0];
  assign tot_hi_o = tot_q[1];
endmodule

// File: rtl/fd_score.sv
module fd_score #(
  parameter int unsigned AW    = 20,
  parameter int unsigned FIT_W = 12,
  parameter int unsigned LIMIT = 1000000
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             fin_i,
  input  logic [AW-1:0]    tot_lo_i,
  input  logic [AW-1:0]    tot_hi_i,
  output logic [FIT_W-1:0] fit_o,
  output logic             done_o
);
  localparam int unsigned PW = AW + FIT_W;
  localparam logic [PW-1:0] FULL  = PW'((64'd1 << FIT_W) - 1);
  localparam logic [PW-1:0] DENOM = PW'(LIMIT);

  logic [AW-1:0]    diff;
  logic [PW-1:0]    prod;
  logic [PW-1:0]    quot;
  logic [FIT_W-1:0] fit_q;
  logic             done_q;

  assign diff = (tot_lo_i >= tot_hi_i) ? tot_lo_i - tot_hi_i : tot_hi_i - tot_lo_i;
  assign prod = PW'(diff) * FULL;
  assign quot = prod / DENOM;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fit_q  <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= fin_i;
      if (fin_i) fit_q <= quot[FIT_W-1:0];
    end
  end

  assign fit_o  = fit_q;
  assign done_o = done_q;

  // R5
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |=> !done_q);
  // R5
  fit_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_q |-> $stable(fit_q));
endmodule

// File: rtl/fd_fitness.sv
module fd_fitness #(
  parameter int unsigned WIN_LEN = 200000,
  parameter int unsigned REPS    = 5,
  parameter int unsigned FIT_W   = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             samp_en_i,
  input  logic             dut_bit_i,
  output logic             tone_sel_o,
  output logic [FIT_W-1:0] fit_o,
  output logic             done_o
);
  localparam int unsigned LIMIT = REPS * WIN_LEN;
  localparam int unsigned AW    = $clog2(LIMIT + 1);

  logic          clr, take, fin;
  logic [AW-1:0] tot_lo, tot_hi;

  fd_sequencer #(.WIN_LEN(WIN_LEN), .REPS(REPS)) u_seq (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .samp_en_i(samp_en_i),
    .clr_o(clr), .take_o(take), .tone_o(tone_sel_o), .fin_o(fin)
  );

  fd_accum #(.AW(AW), .LIMIT(LIMIT)) u_acc (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(clr), .take_i(take),
    .tone_i(tone_sel_o), .bit_i(dut_bit_i), .tot_lo_o(tot_lo), .tot_hi_o(tot_hi)
  );

  fd_score #(.AW(AW), .FIT_W(FIT_W), .LIMIT(LIMIT)) u_score (
    .clk_i(clk_i), .rst_ni(rst_ni), .fin_i(fin), .tot_lo_i(tot_lo),
    .tot_hi_i(tot_hi), .fit_o(fit_o), .done_o(done_o)
  );

  // R5
  done_after_fin_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $past(fin));
  // R8
  idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!take && !clr && !fin) |=> ($stable(tot_lo) && $stable(tot_hi)));
endmodule

// File: tb/sim_fd_fitness.sv
module sim_fd_fitness;
  localparam int WIN  = 20;
  localparam int REPS = 5;
  localparam int FW   = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0, sen = 1'b0, dbit = 1'b0;
  logic tone;
  logic [FW-1:0] fit;
  logic done;
  int checks = 0, errors = 0;
  logic [FW-1:0] last_fit = '0;

  always #4 clk = ~clk;

  fd_fitness #(.WIN_LEN(WIN), .REPS(REPS), .FIT_W(FW)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .samp_en_i(sen),
    .dut_bit_i(dbit), .tone_sel_o(tone), .fit_o(fit), .done_o(done)
  );

  // {ones per low-tone window, ones per high-tone window, gaps, mid-run start}
  localparam logic [17:0] VEC [7] = '{
    {8'd20, 8'd0,  1'b0, 1'b0},
    {8'd0,  8'd20, 1'b1, 1'b0},
    {8'd10, 8'd10, 1'b0, 1'b1},
    {8'd7,  8'd3,  1'b1, 1'b0},
    {8'd1,  8'd0,  1'b0, 1'b0},
    {8'd13, 8'd19, 1'b0, 1'b1},
    {8'd0,  8'd0,  1'b0, 1'b0}
  };

  task automatic chk(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic run_eval(input int a, input int b, input bit gap, input bit mid);
    int exp_fit;
    int sl, sh;
    sl = REPS * a; sh = REPS * b;
    exp_fit = ((sl > sh ? sl - sh : sh - sl) * ((1 << FW) - 1)) / (REPS * WIN);
    start = 1'b1;
    @(posedge clk); #1;
    start = 1'b0;
    for (int w = 0; w < 2 * REPS; w++) begin
      chk("R2 tone", tone, w % 2);
      for (int s = 0; s < WIN; s++) begin
        if (gap && (s % 3 == 1)) begin
          sen = 1'b0; dbit = 1'b1;
          @(posedge clk); #1;
          chk("R3 no advance", tone, w % 2);
        end
        sen  = 1'b1;
        dbit = (s < ((w % 2) ? b : a));
        start = (mid && w == 3 && s == 5);
        @(posedge clk); #1;
        start = 1'b0;
        if (s != WIN - 1) chk("R5 no early done", done, 0);
      end
    end
    sen = 1'b0; dbit = 1'b0;
    chk("R5 done not yet", done, 0);
    chk("R2 tone back", tone, 0);
    @(posedge clk); #1;
    chk("R5 done", done, 1);
    chk(mid ? "R6 R4 fit" : "R4 R7 R9 fit", fit, exp_fit);
    last_fit = FW'(exp_fit);
    @(posedge clk); #1;
    chk("R5 one cycle", done, 0);
    chk("R5 hold", fit, exp_fit);
  endtask

  initial begin
    fork
      begin
        #4;
        chk("R1 done", done, 0);
        chk("R1 fit", fit, 0);
        chk("R1 tone", tone, 0);
        @(posedge clk); #1;
        rst_n = 1'b1;
        @(posedge clk); #1;
        for (int i = 0; i < 7; i++)
          run_eval(int'(VEC[i][17:10]), int'(VEC[i][9:2]), VEC[i][1], VEC[i][0]);
        // R8: strobes while idle
        for (int i = 0; i < 3 * WIN; i++) begin
          sen = 1'b1; dbit = 1'b1;
          @(posedge clk); #1;
          chk("R8 idle done", done, 0);
          chk("R8 idle tone", tone, 0);
        end
        sen = 1'b0; dbit = 1'b0;
        chk("R8 idle fit", fit, last_fit);
        // R9 full scale again after idle noise
        run_eval(WIN, 0, 1'b0, 1'b0);
      end
      begin
        repeat (20000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog actual 0 expected 1");
      end
    join_any
    disable fork;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule